// File: doc/BRIEF.md
# USB Full-Speed Line Condition Monitor

This block sits beside a full-speed USB device controller. It watches the D+/D- line pair, which has already been synchronised into the 48 MHz sampling domain, and measures how long each line state lasts. From those durations it reports four conditions. A bus reset is a long single-ended zero. Suspend is a long idle J. Resume is activity that returns after suspend. Turnaround time-out means no host response within the allowed window while the protocol engine waits for one. On the rising edge of any of these conditions, the block sends a single-cycle pulse to the interrupt logic.

The same block also drives the lines when software asks for it. A remote-wake request forces the K state, which is used to signal a wake-up to the host. A drive-zero request forces both lines low, and this request takes priority. Nothing is driven, and every duration counter is held cleared, while the controller enable is low. The durations are parameters. Their defaults assume four samples per full-speed bit: 120 clocks for reset, 144,000 for suspend and 72 for time-out.

Line encoding on `line_state` is {D+, D-}: 2'b00 single-ended zero, 2'b01 K, 2'b10 J (idle), 2'b11 single-ended one.

Top module: `usb_line_monitor`

## Requirements
- R1: `reset_flag` is high after the clock edge at which the count of consecutive enabled samples of 2'b00 exceeds RESET_CLKS. It drops after the first edge that samples any other code, so 2'b11 never counts.
- R2: `suspend_flag` is high after the edge at which the count of consecutive enabled samples of J (2'b10) exceeds SUSPEND_CLKS. It drops after the first non-J sample.
- R3: A non-J sample taken while `suspend_flag` is high sets `resume_flag` after that edge. `resume_flag` stays set until `reset_flag` or `suspend_flag` becomes high, and it drops in that same cycle. It is never high together with either of them.
- R4: While `resp_wait` is high, `timeout_flag` rises after the edge at which the count of consecutive J samples exceeds TIMEOUT_CLKS. That count starts from the rise of `resp_wait` or from the last line change. Once set, the flag holds through later line activity until the first edge that samples `resp_wait` low.
- R5: Any change of the sampled line code restarts the reset, suspend and time-out durations from one.
- R6: `bus_evt` is high for exactly the one cycle in which any of the four flags goes from low to high, and low in every other cycle.
- R7: With `ctrl_en`, `phy_en` and `rwake_req` high and `force_se0` low, `drive_oe` is 1 and `drive_val` is 2'b01 (K) after the next edge. Releasing the request releases the lines after the next edge.
- R8: `force_se0` takes priority over `rwake_req`. With both enables high it gives `drive_oe` = 1 and `drive_val` = 2'b00 after the next edge. `drive_val` is 2'b00 whenever `drive_oe` is 0.
- R9: `drive_oe` is 0 after any edge that samples `ctrl_en` or `phy_en` low.
- R10: An edge that samples `ctrl_en` low clears all four flags and all durations. After re-enabling, each condition needs its full duration again.
- R11: After `rst_n` is released, all flags, `bus_evt` and the drive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; low clears the monitor and disables driving |
| phy_en | input | 1 | Transceiver enable; required for driving |
| line_state | input | 2 | Synchronised {D+, D-} sample |
| resp_wait | input | 1 | Protocol engine is waiting for a host packet |
| rwake_req | input | 1 | Software request to drive K |
| force_se0 | input | 1 | Software request to drive both lines low |
| reset_flag | output | 1 | Bus reset condition |
| suspend_flag | output | 1 | Suspend condition |
| resume_flag | output | 1 | Resume after suspend |
| timeout_flag | output | 1 | Turnaround time-out |
| bus_evt | output | 1 | One-cycle pulse on any flag rising |
| drive_oe | output | 1 | Transceiver drive enable |
| drive_val | output | 2 | Driven {D+, D-} value |

## Verification
The resume state is the hardest to reach from the ports. It exists only after a full suspend duration of unbroken J, and it must then survive line activity until a reset or a new suspend removes it. The bench shrinks the duration parameters so that the suspend threshold can be walked cycle by cycle. It then injects K, J and single-ended-zero runs, both to enter resume and to clear it by each of its three routes. The same small configuration lets every threshold be swept across its boundary, and lets the drive controls be swept over all sixteen combinations.

// File: rtl/usb_lm_pkg.sv
package usb_lm_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_K   = 2'b01,
    LS_J   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef struct packed {
    logic bus_rst;
    logic susp;
    logic resm;
    logic tmo;
  } cond_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // counter must hold limit+1 so that "exceeds" is representable
  function automatic int unsigned cnt_width(input int unsigned lim);
    return $clog2(lim + 2);
  endfunction

  function automatic logic over_limit(input logic [31:0] len, input int unsigned lim);
    return len > lim;
  endfunction

  function automatic logic [1:0] drive_code(input logic en, input logic rw, input logic se0);
    if (en && se0) return 2'(LS_SE0);
    if (en && rw)  return 2'(LS_K);
    return 2'b00;
  endfunction

endpackage

// File: rtl/lm_dur_cnt.sv
module lm_dur_cnt #(
  parameter int unsigned LIMIT = 120
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   clear,
  input  logic                                   restart,
  output logic [usb_lm_pkg::cnt_width(LIMIT)-1:0] len
);
  import usb_lm_pkg::*;

  localparam int unsigned W   = cnt_width(LIMIT);
  localparam int unsigned SAT = LIMIT + 1;

  logic [W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               len_q <= '0;
    else if (clear)           len_q <= '0;
    else if (restart)         len_q <= W'(1);
    else if (len_q != W'(SAT)) len_q <= len_q + W'(1);
  end

  assign len = len_q;
endmodule

// File: rtl/lm_cond_flags.sv
module lm_cond_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_en,
  input  logic resp_wait,
  input  logic line_is_j,
  input  logic se0_long,
  input  logic idle_long,
  input  logic turn_late,
  output usb_lm_pkg::cond_t flags,
  output logic bus_evt
);
  import usb_lm_pkg::*;

  logic  resm_q;
  logic  tmo_q;
  cond_t prev_q;
  cond_t now_c;
  logic  resume_hit;

  assign resume_hit    = idle_long && !line_is_j;
  assign now_c.bus_rst = se0_long;
  assign now_c.susp    = idle_long;
  assign now_c.resm    = resm_q && !se0_long && !idle_long;
  assign now_c.tmo     = tmo_q || turn_late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resm_q <= 1'b0;
      tmo_q  <= 1'b0;
      prev_q <= '0;
    end else begin
      if (!ctrl_en)        resm_q <= 1'b0;
      else if (resume_hit) resm_q <= 1'b1;
      else                 resm_q <= now_c.resm;
      tmo_q  <= ctrl_en && resp_wait && now_c.tmo;
      prev_q <= now_c;
    end
  end

  assign flags   = now_c;
  assign bus_evt = |(now_c & ~prev_q);
endmodule

// File: rtl/lm_line_drive.sv
module lm_line_drive (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_en,
  input  logic       phy_en,
  input  logic       rwake_req,
  input  logic       force_se0,
  output logic       drive_oe,
  output logic [1:0] drive_val
);
  import usb_lm_pkg::*;

  logic       en;
  logic       oe_q;
  logic [1:0] val_q;

  assign en = ctrl_en && phy_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      val_q <= 2'b00;
    end else begin
      oe_q  <= en && (rwake_req || force_se0);
      val_q <= drive_code(en, rwake_req, force_se0);
    end
  end

  assign drive_oe  = oe_q;
  assign drive_val = val_q;
endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor #(
  parameter int unsigned RESET_CLKS   = 120,
  parameter int unsigned SUSPEND_CLKS = 144000,
  parameter int unsigned TIMEOUT_CLKS = 72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_en,
  input  logic       phy_en,
  input  logic [1:0] line_state,
  input  logic       resp_wait,
  input  logic       rwake_req,
  input  logic       force_se0,
  output logic       reset_flag,
  output logic       suspend_flag,
  output logic       resume_flag,
  output logic       timeout_flag,
  output logic       bus_evt,
  output logic       drive_oe,
  output logic [1:0] drive_val
);
  import usb_lm_pkg::*;

  localparam int unsigned RUN_LIM = max_u(RESET_CLKS, SUSPEND_CLKS);
  localparam int unsigned RUN_W   = cnt_width(RUN_LIM);
  localparam int unsigned TURN_W  = cnt_width(TIMEOUT_CLKS);

  line_e             line_q;
  logic              line_changed;
  logic [RUN_W-1:0]  run_len;
  logic [TURN_W-1:0] turn_len;
  logic              turn_clear;
  logic              se0_long;
  logic              idle_long;
  logic              turn_late;
  cond_t             flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        line_q <= LS_J;
    else if (!ctrl_en) line_q <= LS_J;
    else               line_q <= line_e'(line_state);
  end

  assign line_changed = (line_state != line_q);
  assign turn_clear   = !ctrl_en || !resp_wait || (line_state != LS_J);

  lm_dur_cnt #(.LIMIT(RUN_LIM)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!ctrl_en),
    .restart (line_changed),
    .len     (run_len)
  );

  lm_dur_cnt #(.LIMIT(TIMEOUT_CLKS)) u_turn (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (turn_clear),
    .restart (line_changed),
    .len     (turn_len)
  );

  assign se0_long  = (line_q == LS_SE0) && over_limit(32'(run_len), RESET_CLKS);
  assign idle_long = (line_q == LS_J)   && over_limit(32'(run_len), SUSPEND_CLKS);
  assign turn_late = over_limit(32'(turn_len), TIMEOUT_CLKS);

  lm_cond_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .resp_wait (resp_wait),
    .line_is_j (line_state == LS_J),
    .se0_long  (se0_long),
    .idle_long (idle_long),
    .turn_late (turn_late),
    .flags     (flags),
    .bus_evt   (bus_evt)
  );

  assign reset_flag   = flags.bus_rst;
  assign suspend_flag = flags.susp;
  assign resume_flag  = flags.resm;
  assign timeout_flag = flags.tmo;

  lm_line_drive u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .phy_en    (phy_en),
    .rwake_req (rwake_req),
    .force_se0 (force_se0),
    .drive_oe  (drive_oe),
    .drive_val (drive_val)
  );
endmodule

// File: rtl/usb_line_monitor_chk.sv
module usb_line_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_en,
  input logic       phy_en,
  input logic [1:0] line_state,
  input logic       resp_wait,
  input logic       force_se0,
  input logic       reset_flag,
  input logic       suspend_flag,
  input logic       resume_flag,
  input logic       timeout_flag,
  input logic       bus_evt,
  input logic       drive_oe,
  input logic [1:0] drive_val,
  input logic       line_changed
);

  // R1
  reset_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_flag |-> ($past(line_state) == 2'b00 && $past(ctrl_en)));

  // R2
  susp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_flag |-> ($past(line_state) == 2'b10));

  // R3
  resume_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_flag |-> (!suspend_flag && !reset_flag));

  // R4
  tmo_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> $past(resp_wait));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_changed |=> (!reset_flag && !suspend_flag));

  // R6
  evt_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_flag) |-> bus_evt);

  // R6
  evt_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_flag) |-> bus_evt);

  // R8
  se0_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && force_se0 && ctrl_en && phy_en) |-> (drive_oe && drive_val == 2'b00));

  // R8
  idle_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_oe |-> (drive_val == 2'b00));

  // R9
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_oe |-> $past(ctrl_en && phy_en));

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_en) |-> (!reset_flag && !suspend_flag && !resume_flag && !timeout_flag && !bus_evt));

endmodule

bind usb_line_monitor usb_line_monitor_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_en      (ctrl_en),
  .phy_en       (phy_en),
  .line_state   (line_state),
  .resp_wait    (resp_wait),
  .force_se0    (force_se0),
  .reset_flag   (reset_flag),
  .suspend_flag (suspend_flag),
  .resume_flag  (resume_flag),
  .timeout_flag (timeout_flag),
  .bus_evt      (bus_evt),
  .drive_oe     (drive_oe),
  .drive_val    (drive_val),
  .line_changed (line_changed)
);

// File: tb/usb_line_monitor_bench.sv
`timescale 1ns/100ps
module usb_line_monitor_bench;

  localparam int RST = 6;
  localparam int SUS = 40;
  localparam int TMO = 5;

  localparam logic [1:0] SE0 = 2'b00;
  localparam logic [1:0] KS  = 2'b01;
  localparam logic [1:0] JS  = 2'b10;
  localparam logic [1:0] SE1 = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_en = 1'b0;
  logic phy_en = 1'b0;
  logic [1:0] line_state = 2'b10;
  logic resp_wait = 1'b0;
  logic rwake_req = 1'b0;
  logic force_se0 = 1'b0;
  logic reset_flag, suspend_flag, resume_flag, timeout_flag, bus_evt, drive_oe;
  logic [1:0] drive_val;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_line_monitor #(.RESET_CLKS(RST), .SUSPEND_CLKS(SUS), .TIMEOUT_CLKS(TMO)) u_usb_line_monitor (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .phy_en(phy_en),
    .line_state(line_state), .resp_wait(resp_wait), .rwake_req(rwake_req),
    .force_se0(force_se0), .reset_flag(reset_flag), .suspend_flag(suspend_flag),
    .resume_flag(resume_flag), .timeout_flag(timeout_flag), .bus_evt(bus_evt),
    .drive_oe(drive_oe), .drive_val(drive_val)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    ctrl_en = 1'b0;
    tick();
    ctrl_en = 1'b1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    ticks(3);
    rst_n = 1'b1;
    tick();
    // R11 reset state
    check("R11 flags", {reset_flag, suspend_flag, resume_flag, timeout_flag, bus_evt}, 0);
    check("R11 drive", {drive_oe, drive_val}, 0);

    phy_en = 1'b1;
    // R1 / R6 reset threshold sweep
    clear_mon();
    line_state = SE0;
    for (int i = 1; i <= RST + 3; i++) begin
      tick();
      check("R1 reset sweep", reset_flag, (i > RST));
      check("R6 reset pulse", bus_evt, (i == RST + 1));
    end
    line_state = JS;
    tick();
    check("R1 reset drop", reset_flag, 0);

    // R1 single-ended one never counts
    clear_mon();
    line_state = SE1;
    ticks(RST + 2);
    check("R1 se1 ignored", reset_flag, 0);

    // R5 restart on a one-sample break
    clear_mon();
    line_state = SE0; ticks(RST);
    line_state = JS;  tick();
    line_state = SE0; ticks(RST);
    check("R5 broken run", reset_flag, 0);
    tick();
    check("R5 full run", reset_flag, 1);

    // R2 / R6 suspend sweep
    clear_mon();
    line_state = JS;
    for (int i = 1; i <= SUS + 3; i++) begin
      tick();
      check("R2 suspend sweep", suspend_flag, (i > SUS));
      check("R6 suspend pulse", bus_evt, (i == SUS + 1));
    end
    // R3 resume entry
    line_state = KS;
    tick();
    check("R3 suspend off", suspend_flag, 0);
    check("R3 resume on", resume_flag, 1);
    check("R6 resume pulse", bus_evt, 1);
    tick();
    check("R6 pulse one cycle", bus_evt, 0);
    line_state = JS; tick();
    check("R3 resume holds", resume_flag, 1);
    // R3 cleared by bus reset
    line_state = SE0; ticks(RST + 1);
    check("R3 reset seen", reset_flag, 1);
    check("R3 resume cleared by reset", resume_flag, 0);
    // R3 cleared by new suspend
    line_state = JS; ticks(SUS + 1);
    check("R2 suspend again", suspend_flag, 1);
    line_state = KS; tick();
    check("R3 resume again", resume_flag, 1);
    line_state = JS; ticks(SUS);
    check("R3 resume before suspend", resume_flag, 1);
    tick();
    check("R3 resume cleared by suspend", {suspend_flag, resume_flag}, 2'b10);
    // R10 disable clears resume
    line_state = KS; tick();
    check("R3 resume third", resume_flag, 1);
    ctrl_en = 1'b0; tick();
    check("R10 flags cleared", {reset_flag, suspend_flag, resume_flag, timeout_flag, bus_evt}, 0);
    ctrl_en = 1'b1;

    // R4 / R6 time-out sweep
    clear_mon();
    line_state = JS;
    resp_wait = 1'b1;
    for (int i = 1; i <= TMO + 3; i++) begin
      tick();
      check("R4 timeout sweep", timeout_flag, (i > TMO));
      check("R6 timeout pulse", bus_evt, (i == TMO + 1));
    end
    line_state = KS; tick();
    check("R4 timeout sticky", timeout_flag, 1);
    resp_wait = 1'b0; tick();
    check("R4 timeout release", timeout_flag, 0);

    // R5 time-out restart
    clear_mon();
    line_state = JS; resp_wait = 1'b1;
    ticks(TMO);
    line_state = KS; tick();
    line_state = JS; ticks(TMO);
    check("R5 timeout restart", timeout_flag, 0);
    tick();
    check("R5 timeout after restart", timeout_flag, 1);
    resp_wait = 1'b0;
    clear_mon();
    ticks(TMO + 3);
    check("R4 no wait no timeout", timeout_flag, 0);

    // R10 re-enable needs a full run
    clear_mon();
    line_state = SE0; ticks(RST);
    ctrl_en = 1'b0; tick();
    ctrl_en = 1'b1;
    ticks(RST);
    check("R10 run restarted", reset_flag, 0);
    tick();
    check("R10 full run after enable", reset_flag, 1);

    // R7 / R8 / R9 drive sweep over all combinations
    line_state = JS;
    for (int k = 0; k < 16; k++) begin
      logic c, p, r, s, eoe;
      logic [1:0] ev;
      c = k[3]; p = k[2]; r = k[1]; s = k[0];
      ctrl_en = c; phy_en = p; rwake_req = r; force_se0 = s;
      eoe = c & p & (r | s);
      ev  = (eoe && !s) ? 2'b01 : 2'b00;
      tick();
      if (s) check("R8 se0 drive", {drive_oe, drive_val}, {eoe, ev});
      else if (!(c & p)) check("R9 drive gated", {drive_oe, drive_val}, {eoe, ev});
      else check("R7 k drive", {drive_oe, drive_val}, {eoe, ev});
    end
    rwake_req = 1'b1; force_se0 = 1'b0; ctrl_en = 1'b1; phy_en = 1'b1;
    tick();
    check("R7 k asserted", {drive_oe, drive_val}, 3'b101);
    rwake_req = 1'b0;
    tick();
    check("R7 k released", {drive_oe, drive_val}, 3'b000);

    summary();
  end

endmodule